// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit sits next to the receive and transmit paths of a 16550-style serial port and turns a handful of status conditions into one interrupt request line plus a readable identification byte. Five conditions feed it: a line-status event (overrun, break, framing or parity trouble), the receive FIFO having reached its trigger level, a character timeout, the transmit holding register going empty, and a modem-status change. Software programs a small enable register, and the unit gates each condition with its enable bit. It picks the single highest-priority enabled condition and reports it through the identification register.

Two of the conditions are held inside the unit. A line-status event is latched until the line status register is read. A transmit-empty event is latched on the empty edge and is dropped either when software reads the identification register while it shows the transmit-empty code, or when the holding register is loaded again. The other three conditions are level inputs owned by the FIFO and modem logic. They fall when that logic drains or acknowledges them.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register (address 1) reads 0x00, the identification register (address 2) reads 0xC1, and `irq` is low.
- R2: A write to address 1 stores data bits 3:0 as the enable register. Bit 0 is received-data/timeout, bit 1 is transmit-empty, bit 2 is line-status and bit 3 is modem-status. Bits 7:4 always read back as 0. Any other address reads 0x00.
- R3: The identification byte is {2'b11, 2'b00, code}. The code is 0x1 when nothing enabled is pending. Otherwise it is 0x6 for line status, 0x4 for received data, 0xC for timeout, 0x2 for transmit empty and 0x0 for modem status.
- R4: The priority from high to low is: line status, then received data (above timeout), then transmit empty, then modem status.
- R5: With enable bit 0 clear, neither the trigger-level input nor the timeout input affects `irq` or the identification byte. Other enabled sources still report.
- R6: A pulse on `lsr_event` sets a line-status pending flag one cycle later, which reads as 0xC6 when enabled. A pulse on `lsr_read` clears it. If both arrive in the same cycle, the flag stays set.
- R7: When the timeout input is high and the trigger-level input is low, the identification byte reads 0xCC, provided enable bit 0 is set and no line-status interrupt is pending.
- R8: A low-to-high change of `thr_empty` sets a transmit-empty pending flag. The flag clears when address 2 is read while it shows code 0x2, or when `thr_empty` is low. Reading address 2 while it shows another code leaves the flag set.
- R9: `irq` is high exactly when some enabled source is pending. It falls in the same cycle that the last such source clears.
- R10: Latched sources stay pending while disabled and appear as soon as their enable bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (drives read side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address |
| lsr_event | input | 1 | Line-status error event pulse |
| lsr_read | input | 1 | Line status register read strobe |
| rx_at_trig | input | 1 | Receive FIFO at or above trigger level |
| rx_timeout | input | 1 | Character timeout condition |
| thr_empty | input | 1 | Transmit holding register empty level |
| msr_change | input | 1 | Modem status change pending |
| irq | output | 1 | Interrupt request |

## Verification
The bench first walks a vector table of enable settings against level-source combinations, where the priority between data, timeout and modem status decides the code. A design that ranked timeout above data or modem above transmit-empty would report the wrong code. Directed cases then cover a line-status event arriving together with a status read, where a design giving precedence to the clear would lose the event. They also cover an identification read taken while a higher source hides transmit-empty; a design that cleared on any read would silently drop the transmit-empty interrupt. Finally, a transmit-empty edge is taken while disabled, which a design that gated the latch by the enable would never report.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int DATA_W  = 8;
    localparam int EN_W    = 4;
    localparam int ADDR_W  = 3;

    localparam logic [1:0] FIFO_ON_BITS = 2'b11;

    typedef enum logic [3:0] {
        ID_NONE   = 4'h1,
        ID_LINE   = 4'h6,
        ID_RXDATA = 4'h4,
        ID_TMO    = 4'hC,
        ID_THRE   = 4'h2,
        ID_MODEM  = 4'h0
    } id_code_e;

    typedef struct packed {
        logic modem_en;
        logic line_en;
        logic thre_en;
        logic rx_en;
    } irq_en_t;

    typedef struct packed {
        logic modem;
        logic thre;
        logic tmo;
        logic rxdata;
        logic line;
    } irq_src_t;

    function automatic irq_src_t gate_sources(irq_src_t s, irq_en_t e);
        irq_src_t g;
        g.line   = s.line   & e.line_en;
        g.rxdata = s.rxdata & e.rx_en;
        g.tmo    = s.tmo    & e.rx_en;
        g.thre   = s.thre   & e.thre_en;
        g.modem  = s.modem  & e.modem_en;
        return g;
    endfunction

    function automatic logic [DATA_W-1:0] ident_byte(id_code_e c);
        return {FIFO_ON_BITS, 2'b00, c};
    endfunction

endpackage

// File: rtl/uart_irq_en_reg.sv
module uart_irq_en_reg
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output irq_en_t           en_q,
    output logic [DATA_W-1:0] rd_byte
);
    localparam int PAD_W = DATA_W - EN_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= irq_en_t'(wr_data[EN_W-1:0]);
        end
    end

    assign rd_byte = {{PAD_W{1'b0}}, en_q};

endmodule

// File: rtl/uart_irq_latch.sv
module uart_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic lsr_event,
    input  logic lsr_read,
    input  logic thr_empty,
    input  logic thre_read_clr,
    output logic line_pend,
    output logic thre_pend
);
    logic thr_empty_q;
    logic thr_rise;

    assign thr_rise = thr_empty & ~thr_empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_pend <= 1'b0;
        end else if (lsr_event) begin
            line_pend <= 1'b1;
        end else if (lsr_read) begin
            line_pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_empty_q <= 1'b0;
            thre_pend   <= 1'b0;
        end else begin
            thr_empty_q <= thr_empty;
            if (!thr_empty) begin
                thre_pend <= 1'b0;
            end else if (thr_rise) begin
                thre_pend <= 1'b1;
            end else if (thre_read_clr) begin
                thre_pend <= 1'b0;
            end
        end
    end

    // R6
    ls_set_chk: assert property (@(posedge clk) disable iff (rst)
        lsr_event |=> line_pend);

    // R6
    ls_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (lsr_read && !lsr_event) |=> !line_pend);

    // R8
    thre_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(thr_empty) |=> thre_pend);

    // R8
    thre_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !thr_empty |=> !thre_pend);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  irq_src_t src_gated,
    output id_code_e code,
    output logic     active
);
    always_comb begin
        if (src_gated.line) begin
            code = ID_LINE;
        end else if (src_gated.rxdata) begin
            code = ID_RXDATA;
        end else if (src_gated.tmo) begin
            code = ID_TMO;
        end else if (src_gated.thre) begin
            code = ID_THRE;
        end else if (src_gated.modem) begin
            code = ID_MODEM;
        end else begin
            code = ID_NONE;
        end
    end

    assign active = |src_gated;

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int AW       = ADDR_W,
    parameter int DW       = DATA_W,
    parameter int EN_ADDR  = 1,
    parameter int ID_ADDR  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          lsr_event,
    input  logic          lsr_read,
    input  logic          rx_at_trig,
    input  logic          rx_timeout,
    input  logic          thr_empty,
    input  logic          msr_change,
    output logic          irq
);
    localparam logic [AW-1:0] EN_SEL = AW'(EN_ADDR);
    localparam logic [AW-1:0] ID_SEL = AW'(ID_ADDR);

    irq_en_t           en_q;
    logic [DW-1:0]     en_byte;
    logic              line_pend;
    logic              thre_pend;
    logic              thre_read_clr;
    irq_src_t          src_raw;
    irq_src_t          src_gated;
    id_code_e          code;
    logic              active;
    logic [DW-1:0]     id_val;

    uart_irq_en_reg u_en (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr && (reg_addr == EN_SEL)),
        .wr_data (reg_wdata),
        .en_q    (en_q),
        .rd_byte (en_byte)
    );

    uart_irq_latch u_latch (
        .clk           (clk),
        .rst           (rst),
        .lsr_event     (lsr_event),
        .lsr_read      (lsr_read),
        .thr_empty     (thr_empty),
        .thre_read_clr (thre_read_clr),
        .line_pend     (line_pend),
        .thre_pend     (thre_pend)
    );

    always_comb begin
        src_raw.line   = line_pend;
        src_raw.rxdata = rx_at_trig;
        src_raw.tmo    = rx_timeout;
        src_raw.thre   = thre_pend;
        src_raw.modem  = msr_change;
    end

    assign src_gated = gate_sources(src_raw, en_q);

    uart_irq_prio u_prio (
        .src_gated (src_gated),
        .code      (code),
        .active    (active)
    );

    assign id_val        = ident_byte(code);
    assign thre_read_clr = reg_rd && (reg_addr == ID_SEL) && (code == ID_THRE);
    assign irq           = active;

    always_comb begin
        if (reg_addr == EN_SEL) begin
            reg_rdata = en_byte;
        end else if (reg_addr == ID_SEL) begin
            reg_rdata = id_val;
        end else begin
            reg_rdata = '0;
        end
    end

    // R9
    irq_match_chk: assert property (@(posedge clk) disable iff (rst)
        irq == !id_val[0]);

    // R4
    line_first_chk: assert property (@(posedge clk) disable iff (rst)
        (line_pend && en_q.line_en) |-> (id_val == 8'hC6));

    // R5
    rx_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q.rx_en |-> ((id_val[3:0] != 4'h4) && (id_val[3:0] != 4'hC)));

    // R3
    fifo_bits_chk: assert property (@(posedge clk) disable iff (rst)
        id_val[7:4] == 4'hC);

endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = 3'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       lsr_event = 1'b0;
    logic       lsr_read = 1'b0;
    logic       rx_at_trig = 1'b0;
    logic       rx_timeout = 1'b0;
    logic       thr_empty = 1'b0;
    logic       msr_change = 1'b0;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_irq_ident u_uart_irq_ident (
        .clk        (clk),
        .rst        (rst),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .lsr_event  (lsr_event),
        .lsr_read   (lsr_read),
        .rx_at_trig (rx_at_trig),
        .rx_timeout (rx_timeout),
        .thr_empty  (thr_empty),
        .msr_change (msr_change),
        .irq        (irq)
    );

    // vector: {en[3:0], trig, tmo, msr, exp_irq, exp_id[7:0]}
    localparam int NV = 11;
    localparam logic [15:0] VEC [NV] = '{
        {4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC1},
        {4'hF, 1'b1, 1'b0, 1'b0, 1'b1, 8'hC4},
        {4'hF, 1'b0, 1'b1, 1'b0, 1'b1, 8'hCC},
        {4'hF, 1'b1, 1'b1, 1'b0, 1'b1, 8'hC4},
        {4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC0},
        {4'hF, 1'b1, 1'b0, 1'b1, 1'b1, 8'hC4},
        {4'hE, 1'b1, 1'b1, 1'b1, 1'b1, 8'hC0},
        {4'hE, 1'b1, 1'b1, 1'b0, 1'b0, 8'hC1},
        {4'h7, 1'b0, 1'b0, 1'b1, 1'b0, 8'hC1},
        {4'h8, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC0},
        {4'h1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hCC}
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic peek_id(input string req, input logic [7:0] exp_id, input logic exp_irq);
        reg_addr = 3'd2;
        #1;
        check8(req, reg_rdata, exp_id);
        check8(req, {7'd0, irq}, {7'd0, exp_irq});
    endtask

    task automatic write_en(input logic [7:0] v);
        @(negedge clk);
        reg_addr  = 3'd1;
        reg_wdata = v;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic read_id_strobe();
        @(negedge clk);
        reg_addr = 3'd2;
        reg_rd   = 1'b1;
        @(negedge clk);
        reg_rd   = 1'b0;
    endtask

    task automatic pulse_ls(input logic ev, input logic rd);
        @(negedge clk);
        lsr_event = ev;
        lsr_read  = rd;
        @(negedge clk);
        lsr_event = 1'b0;
        lsr_read  = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        reg_addr = 3'd1;
        #1;
        check8("R1 en", reg_rdata, 8'h00);
        peek_id("R1 id", 8'hC1, 1'b0);

        // R2 upper bits and unused address
        write_en(8'hFF);
        reg_addr = 3'd1;
        #1;
        check8("R2 en readback", reg_rdata, 8'h0F);
        reg_addr = 3'd5;
        #1;
        check8("R2 other addr", reg_rdata, 8'h00);

        // R3 R4 R5 R7 R9 vector walk
        for (int i = 0; i < NV; i++) begin
            write_en({4'h0, VEC[i][15:12]});
            rx_at_trig = VEC[i][11];
            rx_timeout = VEC[i][10];
            msr_change = VEC[i][9];
            peek_id($sformatf("R4 vec %0d", i), VEC[i][7:0], VEC[i][8]);
        end
        rx_timeout = 1'b0;
        msr_change = 1'b0;

        // R6 line status over data
        write_en(8'h0F);
        rx_at_trig = 1'b1;
        peek_id("R6 pre", 8'hC4, 1'b1);
        pulse_ls(1'b1, 1'b0);
        peek_id("R6 set", 8'hC6, 1'b1);
        pulse_ls(1'b0, 1'b1);
        peek_id("R6 clear", 8'hC4, 1'b1);
        pulse_ls(1'b1, 1'b1);
        peek_id("R6 both same cycle", 8'hC6, 1'b1);
        pulse_ls(1'b0, 1'b1);
        rx_at_trig = 1'b0;
        peek_id("R9 idle", 8'hC1, 1'b0);

        // R8 transmit empty set and read clear
        @(negedge clk);
        thr_empty  = 1'b1;
        msr_change = 1'b1;
        @(negedge clk);
        peek_id("R8 thre over modem", 8'hC2, 1'b1);
        msr_change = 1'b0;
        read_id_strobe();
        peek_id("R8 read clear", 8'hC1, 1'b0);

        // R8 hidden transmit-empty survives read
        @(negedge clk);
        thr_empty = 1'b0;
        @(negedge clk);
        thr_empty = 1'b1;
        lsr_event = 1'b1;
        @(negedge clk);
        lsr_event = 1'b0;
        peek_id("R8 line hides thre", 8'hC6, 1'b1);
        read_id_strobe();
        pulse_ls(1'b0, 1'b1);
        peek_id("R8 thre kept", 8'hC2, 1'b1);
        @(negedge clk);
        thr_empty = 1'b0;
        @(negedge clk);
        peek_id("R8 holding loaded", 8'hC1, 1'b0);

        // R10 latched while disabled
        write_en(8'h00);
        @(negedge clk);
        thr_empty = 1'b1;
        @(negedge clk);
        pulse_ls(1'b1, 1'b0);
        peek_id("R10 disabled", 8'hC1, 1'b0);
        write_en(8'h02);
        peek_id("R10 thre appears", 8'hC2, 1'b1);
        write_en(8'h06);
        peek_id("R10 line appears", 8'hC6, 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule